// File: doc/BRIEF.md
# DMA page-bounded address generator

This block produces the transfer address for one DMA channel. A fixed page field sits above an offset counter. Each step strobe moves the offset up or down, and the page bits never take a carry or a borrow. A transfer that runs off the end of a page therefore wraps back to the other end of the same page. It does not spill into the neighbouring page.

Two transfer widths are supported. Byte transfers move the address by one, and the wrap happens inside a 64K window. Word transfers move the address by two, and the wrap happens inside a 128K window. In word mode, bit 0 is never touched by a step. The direction and the width are both sampled on every step, so either one may change between steps. This wrapping behaviour is the mode that is active after reset.

Top module: `dma_page_addr_gen`

## Requirements
- R1: While rst_ni is low, and after it rises, addr_o is zero until the first load.
- R2: When load_i is high, addr_o takes load_addr_i on the next clock edge. A step_i in the same cycle has no effect.
- R3: Byte mode (wide_i=0) with up direction (dir_i=0): one step adds 1 to bits OFF_W-1:0 modulo 2^OFF_W and leaves bits ADDR_W-1:OFF_W unchanged. Example: 01FFFFh becomes 010000h.
- R4: Byte mode with down direction (dir_i=1): one step subtracts 1 from bits OFF_W-1:0 modulo 2^OFF_W and keeps the upper bits. Example: 020000h becomes 02FFFFh.
- R5: Word mode (wide_i=1) with up direction: one step adds 1 to bits OFF_W:1 modulo 2^OFF_W, which moves the address by +2, and keeps bits ADDR_W-1:OFF_W+1. Example: 01FFFEh becomes 000000h.
- R6: Word mode with down direction: one step subtracts 1 from bits OFF_W:1 modulo 2^OFF_W and keeps the upper bits. Example: 020000h becomes 03FFFEh.
- R7: A word-mode step never changes address bit 0.
- R8: When neither load_i nor step_i is high, addr_o holds its value.
- R9: dir_i and wide_i are sampled on each step independently. A sequence of steps that mixes widths and directions gives the composition of the individual steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe, takes priority over step |
| load_addr_i | input | ADDR_W | Initial address to load |
| dir_i | input | 1 | 0 = increment, 1 = decrement |
| wide_i | input | 1 | 0 = byte step (64K page), 1 = word step (128K page) |
| step_i | input | 1 | Advance the address by one transfer |
| addr_o | output | ADDR_W | Current transfer address |

## Verification
The bench builds two instances. The first uses the default ADDR_W=24 and OFF_W=16 and reproduces the exact 24-bit wrap examples. The second uses ADDR_W=8 and OFF_W=3. In that small configuration every one of the 256 start addresses can be loaded and stepped in all four direction and width combinations. Every byte wrap and every word wrap, including odd word-mode starts, is then compared against an arithmetic model.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} dir_e;
  typedef enum logic {XFER_BYTE = 1'b0, XFER_WORD = 1'b1} xfer_e;
endpackage

// File: rtl/dma_addr_wrap_step.sv
module dma_addr_wrap_step #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         down_i,
  output logic [W-1:0] val_o
);
  // modulo 2^W: wrap is implicit in the truncated add
  always_comb val_o = down_i ? (val_i - W'(1)) : (val_i + W'(1));
endmodule

// File: rtl/dma_addr_next.sv
module dma_addr_next
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  dir_e              dir_i,
  input  xfer_e             xfer_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [OFF_W-1:0] byte_nx, word_nx;
  logic down;

  assign down = (dir_i == DIR_DOWN);

  dma_addr_wrap_step #(.W(OFF_W)) u_byte (
    .val_i(cur_i[OFF_W-1:0]), .down_i(down), .val_o(byte_nx));

  dma_addr_wrap_step #(.W(OFF_W)) u_word (
    .val_i(cur_i[OFF_W:1]), .down_i(down), .val_o(word_nx));

  always_comb begin
    if (xfer_i == XFER_WORD)
      next_o = {cur_i[ADDR_W-1:OFF_W+1], word_nx, cur_i[0]};
    else
      next_o = {cur_i[ADDR_W-1:OFF_W], byte_nx};
  end
endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen
  import dma_addr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              dir_i,
  input  logic              wide_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q, addr_nx;

  dma_addr_next #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_next (
    .cur_i (addr_q),
    .dir_i (dir_e'(dir_i)),
    .xfer_i(xfer_e'(wide_i)),
    .next_o(addr_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= '0;
    else if (load_i)  addr_q <= load_addr_i;
    else if (step_i)  addr_q <= addr_nx;
  end

  assign addr_o = addr_q;

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o == $past(load_addr_i));

  assert_byte_page_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !wide_i) |=>
      addr_o[ADDR_W-1:OFF_W] == $past(addr_o[ADDR_W-1:OFF_W]));

  assert_byte_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !wide_i && dir_i) |=>
      OFF_W'($past(addr_o[OFF_W-1:0]) - addr_o[OFF_W-1:0]) == OFF_W'(1));

  assert_word_page_fixed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && wide_i) |=>
      addr_o[ADDR_W-1:OFF_W+1] == $past(addr_o[ADDR_W-1:OFF_W+1]));

  assert_word_bit0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && wide_i) |=> addr_o[0] == $past(addr_o[0]));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(addr_o));
endmodule

// File: tb/dma_page_addr_gen_tb.sv
module dma_page_addr_gen_tb_top;
  localparam int SW = 8;
  localparam int SO = 3;

  logic clk = 0, rst_ni = 0;
  logic load = 0, dir = 0, wide = 0, step = 0;
  logic [23:0] laddr = '0;
  logic [23:0] addr_big;
  logic [SW-1:0] addr_small;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dma_page_addr_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .load_addr_i(laddr),
    .dir_i(dir), .wide_i(wide), .step_i(step), .addr_o(addr_big));

  dma_page_addr_gen #(.ADDR_W(SW), .OFF_W(SO)) small_i (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load), .load_addr_i(laddr[SW-1:0]),
    .dir_i(dir), .wide_i(wide), .step_i(step), .addr_o(addr_small));

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %06h expected %06h", req, act, exp);
    end
  endtask

  function automatic int model(int a, int aw, int ow, bit d, bit w);
    int r;
    if (!w) begin
      int off = a % (1 << ow);
      off = d ? (off + (1 << ow) - 1) % (1 << ow) : (off + 1) % (1 << ow);
      r = (a - (a % (1 << ow))) + off;
    end else begin
      int wo = (a / 2) % (1 << ow);
      wo = d ? (wo + (1 << ow) - 1) % (1 << ow) : (wo + 1) % (1 << ow);
      r = (a - (a % (1 << (ow + 1)))) + wo * 2 + (a % 2);
    end
    return r % (1 << aw);
  endfunction

  // drive at negedge, sample at the following negedge (one register)
  task automatic cyc(bit ld, logic [23:0] la, bit st, bit d, bit w);
    @(negedge clk);
    load = ld; laddr = la; step = st; dir = d; wide = w;
    @(negedge clk);
    load = 0; step = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    load = 1; laddr = 24'hABCDEF; step = 1;
    repeat (2) @(negedge clk);
    check("R1", addr_big, 24'h0);
    load = 0; step = 0;
    rst_ni = 1;
    @(negedge clk);
    check("R1", addr_big, 24'h0);
    check("R1", {16'h0, addr_small}, 24'h0);

    // stated 24-bit corner examples
    cyc(1, 24'h01FFFF, 0, 0, 0); check("R2", addr_big, 24'h01FFFF);
    cyc(0, 0, 1, 0, 0);          check("R3", addr_big, 24'h010000);
    cyc(1, 24'h020000, 0, 0, 0);
    cyc(0, 0, 1, 1, 0);          check("R4", addr_big, 24'h02FFFF);
    cyc(1, 24'h01FFFE, 0, 0, 0);
    cyc(0, 0, 1, 0, 1);          check("R5", addr_big, 24'h000000);
    cyc(1, 24'h020000, 0, 0, 0);
    cyc(0, 0, 1, 1, 1);          check("R6", addr_big, 24'h03FFFE);
    cyc(1, 24'h123457, 0, 0, 0);
    cyc(0, 0, 1, 1, 1);          check("R7", addr_big, 24'h123455);

    // load overrides step in the same cycle
    cyc(1, 24'h3456AB, 1, 0, 0); check("R2", addr_big, 24'h3456AB);
    // hold with no strobes
    cyc(0, 0, 0, 1, 1);          check("R8", addr_big, 24'h3456AB);
    repeat (3) @(negedge clk);
    check("R8", addr_big, 24'h3456AB);

    // mixed sequence: +1 byte, +2 word, -2 word, -1 byte, -1 byte
    cyc(1, 24'h05FFFE, 0, 0, 0);
    cyc(0, 0, 1, 0, 0); check("R9", addr_big, 24'h05FFFF);
    cyc(0, 0, 1, 0, 1); check("R9", addr_big, 24'h040001);
    cyc(0, 0, 1, 1, 1); check("R9", addr_big, 24'h05FFFF);
    cyc(0, 0, 1, 1, 0); check("R9", addr_big, 24'h05FFFE);
    cyc(0, 0, 1, 1, 0); check("R9", addr_big, 24'h05FFFD);

    // exhaustive sweep on the small instance
    for (int a = 0; a < (1 << SW); a++) begin
      for (int m = 0; m < 4; m++) begin
        bit d = m[0];
        bit w = m[1];
        int e;
        cyc(1, 24'(a), 0, 0, 0);
        cyc(0, 0, 1, d, w);
        e = model(a, SW, SO, d, w);
        if (!w) check(d ? "R4" : "R3", {16'h0, addr_small}, 24'(e));
        else    check(d ? "R6" : "R5", {16'h0, addr_small}, 24'(e));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule